// File: doc/BRIEF.md
# ROM-to-RAM Copy and Readout Sequencer

This block is a small controller that owns two 16-word by 8-bit memories. One is a read-only store with a fixed pattern, and the other is a single-port RAM that starts with a different pattern. Both memories register their read data, so a read takes one cycle. After reset the controller holds both memories idle for a short startup delay. It then walks the RAM from address 0 to address 15 and puts each word on the data output. After that it copies the whole read-only pattern into the RAM word by word and returns to the startup state. Every later readout therefore shows the read-only pattern.

The controller does not wait on handshakes to cover memory latency. It follows a fixed cadence of three states per word. Each phase ends when its 4-bit address wraps back to zero, so no separate done counter is needed. The state code, both addresses and the RAM write-data register are brought out as debug outputs. They come straight from the internal registers.

Top module: `mem_copy_seq`

## Requirements
- R1: While `rst` is high, every output reads zero after the next clock edge. State code 0 is the startup state.
- R2: After `rst` falls, the state stays 0 for exactly four clock edges, counted from the edge after the release. On the fourth edge it moves to state 1. Each later return to state 0 repeats the same four-edge wait.
- R3: The readout cycles through state codes 1, 2, 3. The RAM address goes up by one on the edge that leaves state 1. From state 3 the machine goes back to 1, unless the RAM address is 0. A full pass covers 16 words in 48 cycles.
- R4: On the edge that leaves state 1, `data_o` takes the RAM word at the address held before that edge. The first pass after power-up shows the initial RAM image, in which word i is (0x40 + 3*i) mod 256.
- R5: The machine enters copy state 4 straight from state 3, when the RAM address has wrapped to 0. At that point both the RAM address and the read-only address are 0.
- R6: The copy step k cycles through state codes 4, 5, 6. In state 5, `ram_wdata_o` holds read-only word k and `rom_addr_o` reads k+1 mod 16. The RAM address goes up by one on the edge that leaves state 6.
- R7: The copy fills RAM word k with read-only word k. The read-only image is word i = (17*i) XOR 0xA5. After step 15 the machine returns to state 0. Every later readout shows the read-only image in address order.
- R8: Reset does not change either memory. After a reset in the middle of a later readout, the next readout still shows the read-only image.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| data_o | output | 8 | Last word read from the RAM |
| state_o | output | 4 | Current state code |
| ram_addr_o | output | 4 | RAM address register |
| ram_wdata_o | output | 8 | RAM write-data register |
| rom_addr_o | output | 4 | Read-only memory address register |

## Verification
The readout is tried with two images: first the initial RAM pattern, then the read-only pattern after a copy. The two patterns share no word at any address, so a skipped, stale or repeated read shows up as a wrong value. A missing write shows up as an old RAM word in the second pass. A third pass and a pass after a mid-readout reset separate a copy that really landed in memory from data that only passed through the output register. Both startup waits, after reset and after a copy, are timed edge by edge, which catches a startup counter that is not cleared.

// File: rtl/mcs_pkg.sv
package mcs_pkg;
  localparam int STATE_W = 4;

  typedef enum logic [STATE_W-1:0] {
    S_BOOT      = 4'h0,
    S_RD_LATCH  = 4'h1,
    S_RD_ADDR   = 4'h2,
    S_RD_SETTLE = 4'h3,
    S_CP_LOAD   = 4'h4,
    S_CP_WRITE  = 4'h5,
    S_CP_STEP   = 4'h6
  } seq_state_e;
endpackage

// File: rtl/mcs_rom.sv
module mcs_rom #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4,
  parameter int STEP   = 17,
  parameter int MASK   = 'hA5
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [DATA_W-1:0] q_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = DATA_W'((i * STEP) ^ MASK);
  end

  always_ff @(posedge clk) begin
    q_o <= mem[addr_i];
  end
endmodule

// File: rtl/mcs_ram.sv
module mcs_ram #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4,
  parameter int BASE   = 'h40,
  parameter int STEP   = 3
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] q_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = DATA_W'(BASE + i * STEP);
  end

  // read-first single port
  always_ff @(posedge clk) begin
    if (we_i) mem[addr_i] <= wdata_i;
    q_o <= mem[addr_i];
  end
endmodule

// File: rtl/mcs_ctrl.sv
module mcs_ctrl
  import mcs_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int ADDR_W     = 4,
  parameter int START_WAIT = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [DATA_W-1:0]   ram_q_i,
  input  logic [DATA_W-1:0]   rom_q_i,
  output logic                ram_we_o,
  output logic [ADDR_W-1:0]   ram_addr_o,
  output logic [DATA_W-1:0]   ram_wdata_o,
  output logic [ADDR_W-1:0]   rom_addr_o,
  output logic [DATA_W-1:0]   rd_data_o,
  output logic [STATE_W-1:0]  state_o
);
  localparam int CNT_W = $clog2(START_WAIT + 1);

  seq_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] ram_addr_q;
  logic [ADDR_W-1:0] rom_addr_q;
  logic [DATA_W-1:0] rd_q;
  logic [DATA_W-1:0] wd_q;
  logic              we_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= S_BOOT;
      cnt_q      <= '0;
      ram_addr_q <= '0;
      rom_addr_q <= '0;
      rd_q       <= '0;
      wd_q       <= '0;
      we_q       <= 1'b0;
    end else begin
      case (state_q)
        S_BOOT: begin
          if (cnt_q == CNT_W'(START_WAIT)) begin
            cnt_q   <= '0;
            state_q <= S_RD_LATCH;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        S_RD_LATCH: begin
          rd_q       <= ram_q_i;
          ram_addr_q <= ram_addr_q + 1'b1;
          state_q    <= S_RD_ADDR;
        end
        S_RD_ADDR:   state_q <= S_RD_SETTLE;
        S_RD_SETTLE: state_q <= (ram_addr_q == '0) ? S_CP_LOAD : S_RD_LATCH;
        S_CP_LOAD: begin
          wd_q       <= rom_q_i;
          rom_addr_q <= rom_addr_q + 1'b1;
          we_q       <= 1'b1;
          state_q    <= S_CP_WRITE;
        end
        S_CP_WRITE: begin
          we_q    <= 1'b0;
          state_q <= S_CP_STEP;
        end
        S_CP_STEP: begin
          ram_addr_q <= ram_addr_q + 1'b1;
          state_q    <= (rom_addr_q == '0) ? S_BOOT : S_CP_LOAD;
        end
        default: begin
          we_q    <= 1'b0;
          cnt_q   <= '0;
          state_q <= S_BOOT;
        end
      endcase
    end
  end

  assign ram_we_o    = we_q;
  assign ram_addr_o  = ram_addr_q;
  assign ram_wdata_o = wd_q;
  assign rom_addr_o  = rom_addr_q;
  assign rd_data_o   = rd_q;
  assign state_o     = state_q;

  // R2: startup holds until the counter reaches its limit
  p_boot_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_BOOT && cnt_q != CNT_W'(START_WAIT)) |=> state_q == S_BOOT);

  // R3: readout cadence
  p_rd_latch_next_r3: assert property (@(posedge clk) disable iff (rst)
    state_q == S_RD_LATCH |=> state_q == S_RD_ADDR);
  p_rd_addr_next_r3: assert property (@(posedge clk) disable iff (rst)
    state_q == S_RD_ADDR |=> state_q == S_RD_SETTLE);
  p_rd_step_addr_r3: assert property (@(posedge clk) disable iff (rst)
    state_q == S_RD_LATCH |=> ram_addr_q == $past(ram_addr_q) + 1'b1);
  p_state_legal_r3: assert property (@(posedge clk) disable iff (rst)
    state_q inside {S_BOOT, S_RD_LATCH, S_RD_ADDR, S_RD_SETTLE,
                    S_CP_LOAD, S_CP_WRITE, S_CP_STEP});

  // R5: copy starts with both addresses at zero
  p_copy_entry_r5: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_RD_SETTLE && ram_addr_q == '0) |=>
      (state_q == S_CP_LOAD && rom_addr_q == '0));

  // R6: write enable is a single-cycle pulse, only in the write state
  p_we_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    we_q |=> !we_q);
  p_we_state_r6: assert property (@(posedge clk) disable iff (rst)
    we_q |-> state_q == S_CP_WRITE);
endmodule

// File: rtl/mem_copy_seq.sv
module mem_copy_seq (
  input  logic       clk,
  input  logic       rst,
  output logic [7:0] data_o,
  output logic [3:0] state_o,
  output logic [3:0] ram_addr_o,
  output logic [7:0] ram_wdata_o,
  output logic [3:0] rom_addr_o
);
  localparam int DATA_W     = 8;
  localparam int ADDR_W     = 4;
  localparam int START_WAIT = 3;

  logic              ram_we;
  logic [ADDR_W-1:0] ram_addr;
  logic [ADDR_W-1:0] rom_addr;
  logic [DATA_W-1:0] ram_wdata;
  logic [DATA_W-1:0] ram_q;
  logic [DATA_W-1:0] rom_q;

  mcs_rom #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) rom_i (
    .clk(clk), .addr_i(rom_addr), .q_o(rom_q)
  );

  mcs_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) ram_i (
    .clk(clk), .we_i(ram_we), .addr_i(ram_addr), .wdata_i(ram_wdata), .q_o(ram_q)
  );

  mcs_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .START_WAIT(START_WAIT)) ctrl_i (
    .clk(clk), .rst(rst),
    .ram_q_i(ram_q), .rom_q_i(rom_q),
    .ram_we_o(ram_we), .ram_addr_o(ram_addr), .ram_wdata_o(ram_wdata),
    .rom_addr_o(rom_addr), .rd_data_o(data_o), .state_o(state_o)
  );

  assign ram_addr_o  = ram_addr;
  assign ram_wdata_o = ram_wdata;
  assign rom_addr_o  = rom_addr;
endmodule

// File: tb/mem_copy_seq_tb_top.sv
`timescale 1ns/1ps
module mem_copy_seq_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] data_o;
  logic [3:0] state_o;
  logic [3:0] ram_addr_o;
  logic [7:0] ram_wdata_o;
  logic [3:0] rom_addr_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  mem_copy_seq dut_i (
    .clk(clk), .rst(rst), .data_o(data_o), .state_o(state_o),
    .ram_addr_o(ram_addr_o), .ram_wdata_o(ram_wdata_o), .rom_addr_o(rom_addr_o)
  );

  function automatic logic [7:0] rom_img(int i);
    return 8'((i * 17) ^ 'hA5);
  endfunction

  function automatic logic [7:0] ram_img(int i);
    return 8'('h40 + 3 * i);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(state_o == 4'd0,     "R1 state",    state_o, 0);
    chk(data_o == 8'd0,      "R1 data",     data_o, 0);
    chk(ram_addr_o == 4'd0,  "R1 ram_addr", ram_addr_o, 0);
    chk(rom_addr_o == 4'd0,  "R1 rom_addr", rom_addr_o, 0);
    chk(ram_wdata_o == 8'd0, "R1 wdata",    ram_wdata_o, 0);
    rst = 1'b0;
  endtask

  // called at the first negedge of a fresh state-0 visit
  task automatic t_startup();
    for (int k = 1; k <= 3; k++) begin
      @(negedge clk);
      chk(state_o == 4'd0, "R2 hold", state_o, 0);
    end
    @(negedge clk);
    chk(state_o == 4'd1, "R2 leave", state_o, 1);
  endtask

  // called at a negedge with state 1; use_rom picks expected image
  task automatic t_readout(bit use_rom, string req);
    for (int k = 0; k < 16; k++) begin
      chk(state_o == 4'd1, "R3 latch", state_o, 1);
      chk(ram_addr_o == 4'(k), "R3 addr", ram_addr_o, k);
      @(negedge clk);
      chk(state_o == 4'd2, "R3 wait", state_o, 2);
      chk(data_o == (use_rom ? rom_img(k) : ram_img(k)), req, data_o,
          use_rom ? rom_img(k) : ram_img(k));
      @(negedge clk);
      chk(state_o == 4'd3, "R3 settle", state_o, 3);
      @(negedge clk);
    end
    chk(state_o == 4'd4,     "R5 enter", state_o, 4);
    chk(ram_addr_o == 4'd0,  "R5 ram_addr", ram_addr_o, 0);
    chk(rom_addr_o == 4'd0,  "R5 rom_addr", rom_addr_o, 0);
  endtask

  task automatic t_copy();
    for (int k = 0; k < 16; k++) begin
      chk(state_o == 4'd4, "R6 load", state_o, 4);
      chk(ram_addr_o == 4'(k), "R6 ram_addr", ram_addr_o, k);
      @(negedge clk);
      chk(state_o == 4'd5, "R6 write", state_o, 5);
      chk(ram_wdata_o == rom_img(k), "R6 wdata", ram_wdata_o, rom_img(k));
      chk(rom_addr_o == 4'(k + 1), "R6 rom_addr", rom_addr_o, (k + 1) % 16);
      @(negedge clk);
      chk(state_o == 4'd6, "R6 step", state_o, 6);
      @(negedge clk);
      chk(ram_addr_o == 4'(k + 1), "R6 ram_step", ram_addr_o, (k + 1) % 16);
    end
    chk(state_o == 4'd0, "R7 return", state_o, 0);
  endtask

  task automatic t_reset_midrun();
    repeat (20) @(negedge clk);
    t_reset();
    t_startup();
    t_readout(1'b1, "R8 kept");
  endtask

  initial begin
    t_reset();
    t_startup();
    t_readout(1'b0, "R4 first image");
    t_copy();
    t_startup();
    t_readout(1'b1, "R7 second image");
    t_copy();
    t_startup();
    t_readout(1'b1, "R7 third image");
    t_copy();
    t_startup();
    t_reset_midrun();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule